// File: doc/BRIEF.md
# DDR3 Refresh Postponement Scheduler

This block decides when a DDR3 memory controller owes the device a refresh. An internal interval timer fires once every `TREFI_CYC` clock cycles, and each firing adds one refresh to a small debt counter. The controller can keep serving traffic and let refreshes pile up. Each time it actually issues a refresh command, it pulses the acknowledge input and the debt drops by one. The block drives no address, because the device works out the refresh row on its own. A single acknowledge always pays off exactly one refresh.

The block has three registered outputs. The plain request is raised whenever at least one refresh is owed, so the controller can slot one in at a convenient moment. The urgent request is raised once the debt reaches the postponement ceiling of eight. At that point the controller has to stop postponing and refresh before the next interval ends. A sticky error flag records any breach of the protocol. A breach is either a ninth postponement or an acknowledge when nothing is owed. If the controller serves every urgent request within one interval, consecutive refresh commands are never more than nine intervals apart.

Top module: `ref_postpone_sched`

## Requirements
- R1: In the cycle after a clock edge with `rst` high, the debt is zero and `req_o`, `urgent_o` and `err_o` are all low.
- R2: The interval timer fires on the `TREFI_CYC`-th clock edge after reset and on every `TREFI_CYC`-th edge after that. A firing with no acknowledge in the same cycle adds one to the debt, unless the debt is already at the ceiling.
- R3: `req_o` is high exactly when the debt is greater than zero. The outputs are registered, so a debt change made at an edge shows on the outputs right after that same edge.
- R4: `urgent_o` is high exactly when the debt equals the ceiling of 8. Whenever `urgent_o` is high, `req_o` is high as well.
- R5: An acknowledge (`ref_ack_i` high at an edge) with a non-zero debt and no timer firing in that cycle removes exactly one unit of debt.
- R6: When a timer firing and an acknowledge fall in the same cycle, they cancel. The debt keeps its value and no error is raised, even when the debt is zero.
- R7: A timer firing with the debt at 8 and no acknowledge sets `err_o`. The debt stays at 8.
- R8: An acknowledge with zero debt and no timer firing in that cycle sets `err_o`. The debt stays at 0.
- R9: Once `err_o` is set, it stays high until the next reset, whatever the other inputs do.
- R10: A controller that acknowledges in the cycle after every cycle in which `urgent_o` is high never sees `err_o`. With that policy, the gap from reset to the first acknowledge, and between consecutive acknowledges, is at most 9 × `TREFI_CYC` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| ref_ack_i | input | 1 | One-cycle pulse, one per refresh command issued |
| req_o | output | 1 | At least one refresh is owed |
| urgent_o | output | 1 | Postponement ceiling reached; refresh needed now |
| err_o | output | 1 | Sticky flag for a postponement overflow or an unmatched acknowledge |

## Verification
The first pattern lets the debt build up with no acknowledges and then pays it back with spaced pulses. This tells apart increments, decrements and the request threshold. Acknowledges placed on exactly the cycle the timer fires separate true cancellation from an ordered add-then-subtract, and a placement at zero debt catches a false error. Letting the debt run past eight, and acknowledging with nothing owed, drive the two error paths, and the stickiness of the flag is then probed with valid traffic. The last pattern is a controller that acknowledges only on urgent. It shows that the ceiling keeps every gap between refreshes within nine intervals.

// File: rtl/ref_sched_pkg.sv
package ref_sched_pkg;

  // Effect of one cycle's inputs on the refresh debt
  typedef enum logic [2:0] {
    DEBT_HOLD  = 3'd0,
    DEBT_INC   = 3'd1,
    DEBT_DEC   = 3'd2,
    DEBT_OVER  = 3'd3,
    DEBT_UNDER = 3'd4
  } debt_act_e;

  function automatic logic act_is_fault(debt_act_e a);
    return (a == DEBT_OVER) || (a == DEBT_UNDER);
  endfunction

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int TREFI_CYC = 6240
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CNT_W = (TREFI_CYC > 2) ? $clog2(TREFI_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TREFI_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // counter restarts right after every firing
  AST_TICK_RESTART: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> (cnt_q == '0)); // R2

endmodule

// File: rtl/ref_debt_classify.sv
module ref_debt_classify
  import ref_sched_pkg::*;
(
  input  logic      tick_i,
  input  logic      ack_i,
  input  logic      debt_zero_i,
  input  logic      debt_full_i,
  output debt_act_e act_o
);
  always_comb begin
    unique case ({tick_i, ack_i})
      2'b11:   act_o = DEBT_HOLD;
      2'b10:   act_o = debt_full_i ? DEBT_OVER  : DEBT_INC;
      2'b01:   act_o = debt_zero_i ? DEBT_UNDER : DEBT_DEC;
      default: act_o = DEBT_HOLD;
    endcase
  end
endmodule

// File: rtl/ref_debt_counter.sv
module ref_debt_counter
  import ref_sched_pkg::*;
#(
  parameter int MAX_DEBT = 8,
  localparam int DEBT_W = $clog2(MAX_DEBT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  debt_act_e         act_i,
  input  logic              tick_i,
  input  logic              ack_i,
  output logic [DEBT_W-1:0] debt_q,
  output logic [DEBT_W-1:0] debt_d
);
  always_comb begin
    unique case (act_i)
      DEBT_INC: debt_d = debt_q + 1'b1;
      DEBT_DEC: debt_d = debt_q - 1'b1;
      default:  debt_d = debt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) debt_q <= '0;
    else     debt_q <= debt_d;
  end

  AST_TICK_ADDS: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !ack_i && debt_q < DEBT_W'(MAX_DEBT)) |=> debt_q == $past(debt_q) + 1'b1); // R2
  AST_ACK_RETIRES: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !tick_i && debt_q != '0) |=> debt_q == $past(debt_q) - 1'b1); // R5
  AST_CANCEL: assert property (@(posedge clk) disable iff (rst)
    (ack_i && tick_i) |=> $stable(debt_q)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    debt_q <= DEBT_W'(MAX_DEBT)); // R7

endmodule

// File: rtl/ref_postpone_sched.sv
module ref_postpone_sched
  import ref_sched_pkg::*;
#(
  parameter int TREFI_CYC = 6240,
  parameter int MAX_DEBT  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_ack_i,
  output logic req_o,
  output logic urgent_o,
  output logic err_o
);
  localparam int DEBT_W = $clog2(MAX_DEBT + 1);
  localparam logic [DEBT_W-1:0] FULL = DEBT_W'(MAX_DEBT);

  logic              tick;
  debt_act_e         act;
  logic [DEBT_W-1:0] debt_q, debt_d;

  ref_interval_timer #(.TREFI_CYC(TREFI_CYC)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  ref_debt_classify u_classify (
    .tick_i      (tick),
    .ack_i       (ref_ack_i),
    .debt_zero_i (debt_q == '0),
    .debt_full_i (debt_q == FULL),
    .act_o       (act)
  );

  ref_debt_counter #(.MAX_DEBT(MAX_DEBT)) u_debt (
    .clk    (clk),
    .rst    (rst),
    .act_i  (act),
    .tick_i (tick),
    .ack_i  (ref_ack_i),
    .debt_q (debt_q),
    .debt_d (debt_d)
  );

  // outputs registered from the next-state debt so they match debt_q
  always_ff @(posedge clk) begin
    if (rst) begin
      req_o    <= 1'b0;
      urgent_o <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      req_o    <= (debt_d != '0);
      urgent_o <= (debt_d == FULL);
      err_o    <= err_o | act_is_fault(act);
    end
  end

  AST_REQ_TRACKS: assert property (@(posedge clk) disable iff (rst)
    req_o == (debt_q != '0)); // R3
  AST_URGENT_TRACKS: assert property (@(posedge clk) disable iff (rst)
    urgent_o == (debt_q == FULL)); // R4
  AST_URGENT_REQ: assert property (@(posedge clk) disable iff (rst)
    urgent_o |-> req_o); // R4
  AST_OVER_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (tick && !ref_ack_i && debt_q == FULL) |=> err_o && debt_q == FULL); // R7
  AST_UNDER_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (ref_ack_i && !tick && debt_q == '0) |=> err_o && debt_q == '0); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o); // R9

endmodule

// File: tb/test_ref_postpone_sched.sv
module test_ref_postpone_sched;
  localparam int T   = 16;
  localparam int MAX = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_ack_i = 1'b0;
  logic req_o, urgent_o, err_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural reference
  int  m_cyc  = 0;   // index of the next active edge since reset
  int  m_debt = 0;
  bit  m_err  = 0;
  bit  started = 0;
  bit  policy_en = 0;

  always #10 clk = ~clk;

  ref_postpone_sched #(.TREFI_CYC(T), .MAX_DEBT(MAX)) i_ref_postpone_sched (
    .clk(clk), .rst(rst), .ref_ack_i(ref_ack_i),
    .req_o(req_o), .urgent_o(urgent_o), .err_o(err_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic bit tick_next();
    return (m_cyc % T) == (T - 1);
  endfunction

  always @(posedge clk) begin
    started = 1;
    cycles++;
    if (rst) begin
      m_cyc = 0; m_debt = 0; m_err = 0;
    end else begin
      bit tk;
      tk = (m_cyc % T) == (T - 1);
      if (tk && !ref_ack_i) begin
        if (m_debt == MAX) m_err = 1; else m_debt++;
      end else if (!tk && ref_ack_i) begin
        if (m_debt == 0) m_err = 1; else m_debt--;
      end
      m_cyc++;
    end
  end

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (started) begin
      check("R3 req_o", req_o, m_debt > 0);
      check("R4 urgent_o", urgent_o, m_debt == MAX);
      check("R7 R8 R9 err_o", err_o, m_err);
    end
  end

  // controller policy: acknowledge after urgent
  always @(negedge clk) if (policy_en) ref_ack_i = urgent_o;

  always @(posedge clk) begin
    if (cycles >= 20000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
      report();
    end
  end

  task automatic do_reset();
    @(negedge clk); rst = 1; ref_ack_i = 0;
    @(negedge clk); @(negedge clk);
    check("R1 req_o", req_o, 0);
    check("R1 urgent_o", urgent_o, 0);
    check("R1 err_o", err_o, 0);
    rst = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // pulse ack on an edge without a tick
  task automatic ack_off_tick();
    @(negedge clk);
    while (tick_next()) @(negedge clk);
    ref_ack_i = 1;
    @(negedge clk);
    ref_ack_i = 0;
  endtask

  // pulse ack on the tick edge
  task automatic ack_on_tick();
    @(negedge clk);
    while (!tick_next()) @(negedge clk);
    ref_ack_i = 1;
    @(negedge clk);
    ref_ack_i = 0;
  endtask

  initial begin
    do_reset();
    // R2: first tick on the T-th edge
    idle(T - 1);
    check("R2 no debt before first tick", req_o, 0);
    idle(1);
    check("R2 debt after first tick", req_o, 1);
    idle(2 * T);
    check("R2 R3 three owed", m_debt, 3);
    ack_off_tick(); ack_off_tick();
    check("R5 still owed", req_o, 1);
    ack_off_tick();
    check("R5 paid back", req_o, 0);
    check("R5 no error", err_o, 0);

    // R6: cancel at zero debt and at non-zero debt
    ack_on_tick();
    check("R6 cancel at zero", err_o, 0);
    check("R6 debt unchanged", req_o, 0);
    idle(T);
    ack_on_tick();
    check("R6 cancel keeps debt", m_debt, 1);
    check("R6 req stays", req_o, 1);

    // R4, R7, R9: overflow
    do_reset();
    idle(MAX * T);
    check("R4 urgent at ceiling", urgent_o, 1);
    check("R4 req with urgent", req_o, 1);
    idle(T);
    check("R7 overflow flags", err_o, 1);
    check("R7 debt stays full", urgent_o, 1);
    ack_off_tick();
    idle(3);
    check("R9 sticky after ack", err_o, 1);
    check("R9 urgent dropped", urgent_o, 0);

    // R8: ack with nothing owed
    do_reset();
    idle(2);
    ack_off_tick();
    check("R8 underflow flags", err_o, 1);
    check("R8 debt stays zero", req_o, 0);
    idle(T + 2);
    check("R9 sticky across tick", err_o, 1);

    // R10: urgent-driven policy
    do_reset();
    begin
      int last = 0;
      int maxgap = 0;
      policy_en = 1;
      for (int i = 0; i < 14 * T; i++) begin
        @(posedge clk);
        if (ref_ack_i) begin
          if (m_cyc - last > maxgap) maxgap = m_cyc - last;
          last = m_cyc;
        end
      end
      @(negedge clk);
      policy_en = 0;
      ref_ack_i = 0;
      check("R10 no error under policy", err_o, 0);
      check("R10 gap within limit", maxgap <= 9 * T, 1);
      check("R10 acks happened", last > 0, 1);
    end
    idle(2);
    report();
  end
endmodule